// File: doc/BRIEF.md
# Processor Sleep-State Sequencer

This block sits on the platform side of a processor and walks it through three low-power levels: Stop-Grant (the shallowest), Sleep and Deep Sleep. The active-low sleep line moves the processor from Stop-Grant into Sleep. Stopping the bus clock while in Sleep takes it into Deep Sleep. The way back up passes through a settling phase. In that phase the bus clock runs again and the sequencer waits for the processor PLL to lock before it treats the processor as being in Sleep.

All timing comes from `msTick`, a one-cycle pulse taken from an always-on slow clock once per millisecond. A blocking flag tells the bus side to hold off snoops, interrupts and any signal transitions. It rises when Deep Sleep is entered and falls only when Stop-Grant is reached again. While the clock is stopped, the two differential bus-clock outputs are parked at fixed levels.

Top module: `pwr_seq_top`

## Requirements
- R1: `pwrState` reports the level as 0 = Stop-Grant, 1 = Sleep, 2 = Deep Sleep, 3 = settling. `sleepN` is high only in state 0. After reset the state is 0, `clkRunEn` is 1 and `busBlock` is 0.
- R2: From Stop-Grant the block moves to Sleep one clock after `enterReq`=1 is seen with `busActive`=0. While `busActive`=1 it stays in Stop-Grant.
- R3: Deep Sleep is entered only from Sleep. The move happens one clock after a Sleep cycle with `busActive`=0 and `wakeReq`=0. While `busActive`=1 the block stays in Sleep.
- R4: In Sleep that was entered from Stop-Grant, `wakeReq`=1 returns the block to Stop-Grant on the next clock.
- R5: In Deep Sleep `clkRunEn` is 0, `clkOutP` is held at 0 and `clkOutN` is held at 1. In every other state `clkOutP`/`clkOutN` follow `refClkP`/`refClkN`.
- R6: Deep Sleep is left, always towards state 3, only after DWELL_MS+1 `msTick` pulses have been counted inside it.
- R7: A `wakeReq` pulse that arrives in Deep Sleep before the dwell minimum is held. The exit then starts one clock after the last required tick.
- R8: In state 3 the clock runs and `sleepN` stays low. After SETTLE_MS+1 ticks the block enters Sleep, and on the following clock it returns to Stop-Grant.
- R9: `busBlock` is 1 from the first Deep Sleep cycle until Stop-Grant is reached again. It is 0 in Stop-Grant and in a Sleep entered from Stop-Grant.
- R10: `enterReq` has no effect in Deep Sleep or settling. It changes neither the state nor the exit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enterReq | input | 1 | Request to go to a low-power level |
| wakeReq | input | 1 | Request to return to Stop-Grant |
| msTick | input | 1 | One-cycle pulse every millisecond |
| busActive | input | 1 | Bus transactions are still in flight |
| refClkP | input | 1 | Free-running bus clock, true phase |
| refClkN | input | 1 | Free-running bus clock, complement phase |
| sleepN | output | 1 | Sleep line to the processor, active low |
| clkRunEn | output | 1 | Bus clock enable |
| clkOutP | output | 1 | Gated bus clock, phase 0 (parked low) |
| clkOutN | output | 1 | Gated bus clock, phase 1 (parked high) |
| pwrState | output | 2 | Current level encoding |
| busBlock | output | 1 | No snoops, interrupts or bus transitions allowed |

## Verification
The assertions assume that `msTick` is a single-cycle pulse and that ticks are spaced widely enough for the checker's tick count to match the sequencer's. They also assume reset is applied before the first request. The bench drives ticks only as isolated one-cycle pulses, separated by idle cycles. It changes all inputs on the falling edge, so no request overlaps a state change in the same cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_STOPGRANT = 2'd0,
    PS_SLEEP     = 2'd1,
    PS_DEEP      = 2'd2,
    PS_SETTLE    = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic cntClear;
    logic cntEnable;
    logic selSettle;
    logic clkRun;
  } seqStrobe_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
  import pwr_seq_pkg::*;
#(
  parameter int DWELL_TICKS  = 26,
  parameter int SETTLE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       msTick,
  input  logic       refClkP,
  input  logic       refClkN,
  output logic       limitHit,
  output logic       clkOutP,
  output logic       clkOutN
);
  localparam int MAX_TICKS = (DWELL_TICKS > SETTLE_TICKS) ? DWELL_TICKS : SETTLE_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] DWELL_L  = CW'(DWELL_TICKS);
  localparam logic [CW-1:0] SETTLE_L = CW'(SETTLE_TICKS);

  logic [CW-1:0] tickCnt;
  logic [CW-1:0] limitSel;

  assign limitSel = strb.selSettle ? SETTLE_L : DWELL_L;
  assign limitHit = (tickCnt == limitSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      tickCnt <= '0;
    else if (strb.cntClear)                         tickCnt <= '0;
    else if (strb.cntEnable && msTick && !limitHit) tickCnt <= tickCnt + 1'b1;
  end

  // parked levels while the clock is stopped: phase 0 low, phase 1 high
  assign clkOutP = strb.clkRun ? refClkP : 1'b0;
  assign clkOutN = strb.clkRun ? refClkN : 1'b1;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       wakeReq,
  input  logic       busActive,
  input  logic       limitHit,
  output seqStrobe_t strb,
  output pwrState_t  state,
  output logic       sleepN,
  output logic       busBlock
);
  pwrState_t nxt;
  logic wakePending;
  logic returning;

  always_comb begin
    nxt            = state;
    strb.cntEnable = 1'b0;
    strb.selSettle = 1'b0;
    unique case (state)
      PS_STOPGRANT: if (enterReq && !busActive) nxt = PS_SLEEP;
      PS_SLEEP: begin
        if (returning || wakeReq) nxt = PS_STOPGRANT;
        else if (!busActive)      nxt = PS_DEEP;
      end
      PS_DEEP: begin
        strb.cntEnable = 1'b1;
        if (limitHit && (wakePending || wakeReq)) nxt = PS_SETTLE;
      end
      PS_SETTLE: begin
        strb.cntEnable = 1'b1;
        strb.selSettle = 1'b1;
        if (limitHit) nxt = PS_SLEEP;
      end
      default: nxt = PS_STOPGRANT;
    endcase
    strb.cntClear = (nxt != state);
    strb.clkRun   = (state != PS_DEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= PS_STOPGRANT;
      wakePending <= 1'b0;
      returning   <= 1'b0;
    end else begin
      state       <= nxt;
      wakePending <= (state == PS_DEEP && nxt == PS_DEEP) ? (wakePending | wakeReq) : 1'b0;
      returning   <= (state == PS_SETTLE);
    end
  end

  assign sleepN   = (state == PS_STOPGRANT);
  assign busBlock = (state == PS_DEEP) || (state == PS_SETTLE) ||
                    (state == PS_SLEEP && returning);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int DWELL_MS  = 25,
  parameter int SETTLE_MS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       wakeReq,
  input  logic       msTick,
  input  logic       busActive,
  input  logic       refClkP,
  input  logic       refClkN,
  output logic       sleepN,
  output logic       clkRunEn,
  output logic       clkOutP,
  output logic       clkOutN,
  output logic [1:0] pwrState,
  output logic       busBlock
);
  // one extra tick covers the partial first millisecond
  localparam int DWELL_TICKS  = DWELL_MS + 1;
  localparam int SETTLE_TICKS = SETTLE_MS + 1;

  seqStrobe_t strb;
  pwrState_t  state;
  logic       limitHit;

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .wakeReq(wakeReq),
    .busActive(busActive), .limitHit(limitHit), .strb(strb),
    .state(state), .sleepN(sleepN), .busBlock(busBlock)
  );

  pwr_seq_timer #(.DWELL_TICKS(DWELL_TICKS), .SETTLE_TICKS(SETTLE_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .strb(strb), .msTick(msTick),
    .refClkP(refClkP), .refClkN(refClkN), .limitHit(limitHit),
    .clkOutP(clkOutP), .clkOutN(clkOutN)
  );

  assign clkRunEn = strb.clkRun;
  assign pwrState = state;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int DWELL_MS = 25
) (
  input logic       clk,
  input logic       rstN,
  input logic       msTick,
  input logic [1:0] pwrState,
  input logic       sleepN,
  input logic       clkRunEn,
  input logic       clkOutP,
  input logic       clkOutN,
  input logic       busBlock
);
  logic [31:0] deepTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             deepTicks <= '0;
    else if (pwrState != 2'd2)             deepTicks <= '0;
    else if (msTick && deepTicks != '1)    deepTicks <= deepTicks + 1'b1;
  end

  AST_SLEEP_LINE: assert property (@(posedge clk) disable iff (!rstN)
    sleepN == (pwrState == 2'd0)); // R1
  AST_DEEP_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrState == 2'd2) |-> $past(pwrState) == 2'd1); // R3
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 |-> (!clkRunEn && !clkOutP && clkOutN)); // R5
  AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrState == 2'd2) |-> ($past(deepTicks) >= 32'(DWELL_MS + 1))); // R6
  AST_SETTLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrState == 2'd3) |-> $past(pwrState) == 2'd2); // R8
  AST_BLOCK_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 || pwrState == 2'd3) |-> busBlock); // R9
  AST_BLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd0 |-> !busBlock); // R9
endmodule

bind pwr_seq_top pwr_seq_chk #(.DWELL_MS(DWELL_MS)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .pwrState(pwrState),
  .sleepN(sleepN), .clkRunEn(clkRunEn), .clkOutP(clkOutP),
  .clkOutN(clkOutN), .busBlock(busBlock)
);

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;
  localparam int DWELL_MS  = 3;
  localparam int SETTLE_MS = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enterReq = 1'b0, wakeReq = 1'b0, msTick = 1'b0, busActive = 1'b0;
  logic refClkP = 1'b1, refClkN = 1'b0;
  logic sleepN, clkRunEn, clkOutP, clkOutN, busBlock;
  logic [1:0] pwrState;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_top #(.DWELL_MS(DWELL_MS), .SETTLE_MS(SETTLE_MS)) i_pwr_seq_top (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .wakeReq(wakeReq),
    .msTick(msTick), .busActive(busActive), .refClkP(refClkP), .refClkN(refClkN),
    .sleepN(sleepN), .clkRunEn(clkRunEn), .clkOutP(clkOutP), .clkOutN(clkOutN),
    .pwrState(pwrState), .busBlock(busBlock)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1;
    step(1);
    msTick = 1'b0;
    step(1);
  endtask

  task automatic enterDeep();
    enterReq = 1'b1; busActive = 1'b0;
    step(1);
    enterReq = 1'b0;
    step(1);
  endtask

  task automatic tResetState();
    check("R1 reset state", {6'd0, pwrState}, 8'd0);
    check("R1 reset sleepN", {7'd0, sleepN}, 8'd1);
    check("R1 reset clkRunEn", {7'd0, clkRunEn}, 8'd1);
    check("R9 reset busBlock", {7'd0, busBlock}, 8'd0);
    check("R5 clock follows ref", {6'd0, clkOutP, clkOutN}, {6'd0, refClkP, refClkN});
  endtask

  task automatic tShallowSleep();
    busActive = 1'b1; enterReq = 1'b1;
    step(2);
    check("R2 bus active holds Stop-Grant", {6'd0, pwrState}, 8'd0);
    busActive = 1'b0;
    step(1);
    check("R2 enter Sleep", {6'd0, pwrState}, 8'd1);
    busActive = 1'b1; enterReq = 1'b0;
    step(2);
    check("R3 bus active holds Sleep", {6'd0, pwrState}, 8'd1);
    check("R1 sleepN low in Sleep", {7'd0, sleepN}, 8'd0);
    check("R9 no block in shallow Sleep", {7'd0, busBlock}, 8'd0);
    wakeReq = 1'b1;
    step(1);
    wakeReq = 1'b0; busActive = 1'b0;
    check("R4 wake from Sleep", {6'd0, pwrState}, 8'd0);
    step(1);
  endtask

  task automatic tEarlyWake();
    enterDeep();
    check("R3 Deep after Sleep", {6'd0, pwrState}, 8'd2);
    refClkP = 1'b1; refClkN = 1'b0;
    step(1);
    check("R5 clock parked", {5'd0, clkRunEn, clkOutP, clkOutN}, 8'b001);
    check("R9 block in Deep", {7'd0, busBlock}, 8'd1);
    wakeReq = 1'b1;
    step(1);
    wakeReq = 1'b0;
    for (int i = 0; i < DWELL_MS; i++) tick();
    check("R7 wake held before minimum", {6'd0, pwrState}, 8'd2);
    msTick = 1'b1;
    step(1);
    msTick = 1'b0;
    check("R6 still Deep at last tick", {6'd0, pwrState}, 8'd2);
    step(1);
    check("R7 pending wake starts exit", {6'd0, pwrState}, 8'd3);
    check("R8 settle clock runs", {6'd0, clkRunEn, sleepN}, 8'b10);
    check("R9 block in settle", {7'd0, busBlock}, 8'd1);
    for (int i = 0; i < SETTLE_MS; i++) tick();
    check("R8 still settling", {6'd0, pwrState}, 8'd3);
    msTick = 1'b1;
    step(1);
    msTick = 1'b0;
    step(1);
    check("R8 Sleep after settle", {6'd0, pwrState}, 8'd1);
    check("R9 block until Stop-Grant", {7'd0, busBlock}, 8'd1);
    step(1);
    check("R8 back to Stop-Grant", {6'd0, pwrState}, 8'd0);
    check("R9 block released", {7'd0, busBlock}, 8'd0);
  endtask

  task automatic tLateWakeIgnoreEnter();
    enterDeep();
    enterReq = 1'b1;
    for (int i = 0; i < DWELL_MS + 3; i++) tick();
    check("R10 enterReq ignored in Deep", {6'd0, pwrState}, 8'd2);
    check("R6 no exit without wake", {6'd0, pwrState}, 8'd2);
    wakeReq = 1'b1;
    step(1);
    wakeReq = 1'b0;
    check("R6 late wake exits at once", {6'd0, pwrState}, 8'd3);
    for (int i = 0; i < SETTLE_MS; i++) tick();
    check("R10 enterReq ignored in settle", {6'd0, pwrState}, 8'd3);
    enterReq = 1'b0;
    tick();
    step(1);
    check("R8 Stop-Grant after late wake", {6'd0, pwrState}, 8'd0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    tResetState();
    tShallowSleep();
    tEarlyWake();
    tLateWakeIgnoreEnter();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule